// File: doc/BRIEF.md
# Sequential Floating-Point Multiplier (Shift-and-Add)

This block multiplies two single-precision floating-point numbers over several clock cycles. An operand pair enters through a valid/ready handshake. The block has no input buffering: `in_ready` is high only while the block is idle, so a caller that holds `in_valid` high while the block is busy waits until the block takes the pair. While a product is being formed, `in_valid` is ignored.

The work is split into three phases. One cycle adds the exponent fields and removes the bias. Twenty-four cycles build the 48-bit significand product, with one conditional add and one right shift per cycle. One final cycle normalizes with at most one shift, truncates the significand and packs the result. The output side is a one-cycle `out_valid` pulse with no back-pressure, so the consumer must capture `out_result` in that cycle.

If either operand has a zero exponent field, the block returns a zero with the product sign on the next cycle and does not iterate. Rounding, NaN, infinity, denormal inputs and exception flags are not handled.

Top module: `fpm_seq_mul`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: A pair is taken on a rising edge where `in_valid` and `in_ready` are both 1. For a pair with no zero operand, `in_ready` is 0 from the next cycle until the cycle in which `out_valid` is high.
- R3: For a pair with no zero operand, `out_valid` is high for exactly one cycle, 26 rising edges after the acceptance edge.
- R4: The result sign (bit 31) is the XOR of the operand signs (bit 31 of each operand).
- R5: With exponent fields in bits 30:23 and stored significands in bits 22:0, the biased result exponent is ea + eb − 127, plus 1 when the 48-bit product of the two 24-bit significands (each with its hidden 1) has bit 47 set. The result significand is product bits 46:24 when bit 47 is set, and bits 45:23 otherwise.
- R6: If either operand has an exponent field of 0, the result is {sign, 31'b0} with `out_valid` high in the cycle right after the acceptance edge.
- R7: If the adjusted exponent is 255 or more, the result saturates to {sign, 8'hFE, 23'h7FFFFF}.
- R8: If the adjusted exponent is 0 or less, the result is {sign, 31'b0}.
- R9: A pair offered with `in_valid` high while the block is busy is ignored. It is not taken and does not change the result in progress.
- R10: Product bits below the kept 23 never change the result. The result is truncated and never rounded up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair valid |
| in_ready | output | 1 | Block idle and able to take a pair |
| in_a | input | 32 | First operand, single precision |
| in_b | input | 32 | Second operand, single precision |
| out_valid | output | 1 | One-cycle pulse marking a valid result |
| out_result | output | 32 | Product, single precision |

## Verification
The bench builds the block with its default parameters: an 8-bit exponent and a 23-bit stored significand. These values give the full 24-step iteration and the exact 127 bias. They also put the saturation and flush-to-zero limits at exponent values the bench can drive directly. At these sizes the bench can compute the 48-bit product as a plain integer, so the truncation boundary and the single normalization shift are checked bit for bit against an independent model on every cycle.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EXP  = 2'd1,
    ST_MUL  = 2'd2,
    ST_NORM = 2'd3
  } fpm_state_e;
endpackage

// File: rtl/fpm_exp_add.sv
module fpm_exp_add #(
  parameter int EXP_W = 8,
  localparam int EXS_W = EXP_W + 2
) (
  input  logic [EXP_W-1:0]        exp_a,
  input  logic [EXP_W-1:0]        exp_b,
  output logic signed [EXS_W-1:0] exp_sum
);
  localparam logic signed [EXS_W-1:0] BIAS = EXS_W'((1 << (EXP_W - 1)) - 1);

  logic signed [EXS_W-1:0] ea_s, eb_s;

  always_comb begin
    ea_s    = $signed({2'b00, exp_a});
    eb_s    = $signed({2'b00, exp_b});
    exp_sum = ea_s + eb_s - BIAS;
  end
endmodule

// File: rtl/fpm_sig_mult.sv
module fpm_sig_mult #(
  parameter int SIG_W = 24,
  localparam int CNT_W = $clog2(SIG_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SIG_W-1:0] mcand_in,
  input  logic [SIG_W-1:0] mplier_in,
  input  logic             step,
  output logic             last,
  output logic [SIG_W:0]   prod_top
);
  logic [2*SIG_W-1:0] acc;
  logic [SIG_W-1:0]   mcand;
  logic [CNT_W-1:0]   cnt;
  logic [SIG_W:0]     part;

  // conditional add of the multiplicand into the upper half
  always_comb begin
    part = {1'b0, acc[2*SIG_W-1:SIG_W]} + (acc[0] ? {1'b0, mcand} : '0);
    last = step && (cnt == CNT_W'(SIG_W - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= '0;
      mcand <= '0;
      cnt   <= '0;
    end else if (load) begin
      acc   <= {{SIG_W{1'b0}}, mplier_in};
      mcand <= mcand_in;
      cnt   <= '0;
    end else if (step) begin
      acc <= {part, acc[SIG_W-1:1]};
      cnt <= last ? '0 : cnt + 1'b1;
    end
  end

  assign prod_top = acc[2*SIG_W-1:SIG_W-1];

  // R5: two normalized significands give a product with one of its two top bits set
  p_prod_norm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (prod_top[SIG_W] || prod_top[SIG_W-1]));

  // R3: the iteration counter never passes the step count
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNT_W'(SIG_W));
endmodule

// File: rtl/fpm_normalize.sv
module fpm_normalize #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int SIG_W = MAN_W + 1,
  localparam int EXS_W = EXP_W + 2,
  localparam int W     = 1 + EXP_W + MAN_W
) (
  input  logic                    sign,
  input  logic signed [EXS_W-1:0] exp_sum,
  input  logic [SIG_W:0]          prod_top,
  output logic [W-1:0]            result
);
  localparam logic signed [EXS_W-1:0] EMAX = EXS_W'((1 << EXP_W) - 1);

  logic                    hi;
  logic [MAN_W-1:0]        mant;
  logic signed [EXS_W-1:0] exp_n;

  always_comb begin
    hi    = prod_top[SIG_W];
    mant  = hi ? prod_top[SIG_W-1 -: MAN_W] : prod_top[SIG_W-2 -: MAN_W];
    exp_n = exp_sum + $signed({{(EXS_W-1){1'b0}}, hi});
    if (exp_n >= EMAX)
      result = {sign, EXP_W'(EMAX - 1), {MAN_W{1'b1}}};
    else if (exp_n <= 0)
      result = {sign, {(W-1){1'b0}}};
    else
      result = {sign, exp_n[EXP_W-1:0], mant};
  end
endmodule

// File: rtl/fpm_seq_mul.sv
module fpm_seq_mul
  import fpm_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int SIG_W = MAN_W + 1,
  localparam int EXS_W = EXP_W + 2,
  localparam int W     = 1 + EXP_W + MAN_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic         out_valid,
  output logic [W-1:0] out_result
);
  fpm_state_e              state;
  logic                    sign_q;
  logic [EXP_W-1:0]        ea_q, eb_q;
  logic signed [EXS_W-1:0] exp_sum, exp_q;
  logic                    accept, opnd_zero, mul_last, sign_in;
  logic [SIG_W:0]          prod_top;
  logic [W-1:0]            norm_res;

  always_comb begin
    in_ready  = (state == ST_IDLE);
    accept    = in_valid && in_ready;
    opnd_zero = (in_a[W-2 -: EXP_W] == '0) || (in_b[W-2 -: EXP_W] == '0);
    sign_in   = in_a[W-1] ^ in_b[W-1];
  end

  fpm_exp_add #(.EXP_W(EXP_W)) i_exp (
    .exp_a(ea_q), .exp_b(eb_q), .exp_sum(exp_sum)
  );

  fpm_sig_mult #(.SIG_W(SIG_W)) i_sig (
    .clk(clk), .rst_n(rst_n),
    .load(accept && !opnd_zero),
    .mcand_in({1'b1, in_a[MAN_W-1:0]}),
    .mplier_in({1'b1, in_b[MAN_W-1:0]}),
    .step(state == ST_MUL),
    .last(mul_last),
    .prod_top(prod_top)
  );

  fpm_normalize #(.EXP_W(EXP_W), .MAN_W(MAN_W)) i_norm (
    .sign(sign_q), .exp_sum(exp_q), .prod_top(prod_top), .result(norm_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      sign_q     <= 1'b0;
      ea_q       <= '0;
      eb_q       <= '0;
      exp_q      <= '0;
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          sign_q <= sign_in;
          if (opnd_zero) begin
            out_result <= {sign_in, {(W-1){1'b0}}};
            out_valid  <= 1'b1;
          end else begin
            ea_q  <= in_a[W-2 -: EXP_W];
            eb_q  <= in_b[W-2 -: EXP_W];
            state <= ST_EXP;
          end
        end
        ST_EXP: begin
          exp_q <= exp_sum;
          state <= ST_MUL;
        end
        ST_MUL: if (mul_last) state <= ST_NORM;
        ST_NORM: begin
          out_result <= norm_res;
          out_valid  <= 1'b1;
          state      <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: a pair that needs iteration makes the block busy on the next cycle
  p_busy_after_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !opnd_zero) |=> !in_ready);

  // R3: the normalize cycle delivers the result pulse
  p_norm_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_NORM) |=> (out_valid && in_ready));

  // R6: a zero operand gives a signed zero on the very next cycle
  p_zero_fast_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && opnd_zero) |=> (out_valid && out_result[W-2:0] == '0));

  // R7: a result never carries the all-ones exponent field
  p_no_maxexp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_result[W-2 -: EXP_W] != '1));
endmodule

// File: tb/test_fpm_seq_mul.sv
`timescale 1ns/1ps
module test_fpm_seq_mul;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_a = '0, in_b = '0;
  logic        in_ready, out_valid;
  logic [31:0] out_result;

  int checks = 0;
  int errors = 0;

  // reference model state
  int          m_cnt = 0;
  logic        m_valid = 1'b0;
  logic [31:0] m_res = '0, m_pend = '0;
  string       m_tag = "R5", m_pend_tag = "R5";

  always #4 clk = ~clk;

  fpm_seq_mul i_fpm_seq_mul (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_result(out_result)
  );

  function automatic logic [31:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
    logic        s;
    longint      p;
    int          e;
    logic [22:0] m;
    s = a[31] ^ b[31];
    if (a[30:23] == 0 || b[30:23] == 0) return {s, 31'b0};
    p = longint'({1'b1, a[22:0]}) * longint'({1'b1, b[22:0]});
    e = int'(a[30:23]) + int'(b[30:23]) - 127;
    if (p[47]) begin m = p[46:24]; e = e + 1; end
    else m = p[45:23];
    if (e >= 255) return {s, 8'hFE, 23'h7FFFFF};
    if (e <= 0) return {s, 31'b0};
    return {s, e[7:0], m};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one clock: drive inputs, advance the model, compare after the edge
  task automatic cycle(input bit v, input logic [31:0] a, input logic [31:0] b, input string tag);
    in_valid = v; in_a = a; in_b = b;
    m_valid = 1'b0;
    if (m_cnt > 0) begin
      m_cnt--;
      if (m_cnt == 0) begin m_valid = 1'b1; m_res = m_pend; m_tag = m_pend_tag; end
    end else if (v) begin
      if (a[30:23] == 0 || b[30:23] == 0) begin
        m_valid = 1'b1; m_res = ref_mul(a, b); m_tag = tag;
      end else begin
        m_cnt = 26; m_pend = ref_mul(a, b); m_pend_tag = tag;
      end
    end
    @(posedge clk);
    @(negedge clk);
    check(in_ready == (m_cnt == 0), "R2", "in_ready", 32'(in_ready), 32'(m_cnt == 0));
    check(out_valid == m_valid, "R3", "out_valid", 32'(out_valid), 32'(m_valid));
    if (m_valid) check(out_result == m_res, m_tag, "result", out_result, m_res);
  endtask

  task automatic op(input logic [31:0] a, input logic [31:0] b, input string tag);
    cycle(1'b1, a, b, tag);
    while (m_cnt > 0) cycle(1'b0, '0, '0, tag);
    cycle(1'b0, '0, '0, tag);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL R3 watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(in_ready == 1'b1, "R1", "in_ready after reset", 32'(in_ready), 32'd1);
    check(out_valid == 1'b0, "R1", "out_valid after reset", 32'(out_valid), 32'd0);

    op(32'h3F800000, 32'h3F800000, "R5");   // 1*1
    op(32'h3FC00000, 32'h3FC00000, "R5");   // 1.5*1.5 normalization shift
    op(32'h40000000, 32'h40400000, "R5");   // 2*3
    op(32'hC0000000, 32'h40400000, "R4");   // -2*3
    op(32'hC0000000, 32'hC0400000, "R4");   // -2*-3
    op(32'h00000000, 32'h40400000, "R6");   // zero operand
    op(32'h40400000, 32'h80000000, "R6");   // negative zero operand
    op(32'h7F000000, 32'h7F000000, "R7");   // overflow saturates
    op(32'hFF7FFFFF, 32'h7F7FFFFF, "R7");   // overflow, negative
    op(32'h00800000, 32'h00800000, "R8");   // underflow flushes
    op(32'h80800000, 32'h3F000000, "R8");   // exactly reaches zero exponent
    op(32'h3F800001, 32'h3F800001, "R10");  // (1+2^-23)^2 truncated
    op(32'h3FFFFFFF, 32'h3FFFFFFF, "R10");  // all-ones significands
    op(32'h3F800000, 32'h3FFFFFFF, "R10");

    // R9: offers during busy are ignored
    cycle(1'b1, 32'h40400000, 32'h40400000, "R9");
    for (int k = 0; k < 5; k++) cycle(1'b1, 32'h3F800000, 32'h00000000, "R9");
    while (m_cnt > 0) cycle(1'b1, 32'hC1200000, 32'h41200000, "R9");
    cycle(1'b0, '0, '0, "R9");
    check(in_ready == 1'b1, "R9", "idle after ignored offers", 32'(in_ready), 32'd1);

    // back-to-back: hold valid into the cycle the result appears
    cycle(1'b1, 32'h40A00000, 32'h40A00000, "R3");
    while (m_cnt > 0) cycle(1'b0, '0, '0, "R3");
    cycle(1'b1, 32'h00000000, 32'hC0000000, "R6");
    cycle(1'b0, '0, '0, "R6");

    for (int k = 0; k < 40; k++) begin
      logic [31:0] ra, rb;
      ra = {1'(($urandom) & 1), 8'(1 + ($urandom % 254)), 23'($urandom)};
      rb = {1'(($urandom) & 1), 8'(1 + ($urandom % 254)), 23'($urandom)};
      op(ra, rb, "R5");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule